// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Overrides

This block is an eight-pin general-purpose I/O port placed on a small register bus. Software selects each pin's direction, writes the values that output pins drive, and reads back either the held output values or the levels seen on the pins. The pad side is a tri-state model with three signals per pin: output data, output enable and pull-up enable.

A single pull-up control bit lives outside the port. It arrives as an input and enables weak pull-ups on all pins at once. The port turns off the pull-up on any pin it is driving. Two peripherals can take over individual pins through per-pin select inputs. The two-wire serial function can claim any pin. The parallel data path can claim only the low pins. On a claimed pin the peripheral decides both the drive and the data, whatever the direction and latch registers hold. Pin levels pass through a two-stage synchronizer before software or the parallel path can read them.

Register map (two-bit address): 0 holds the direction, 1 holds the output latch, 2 returns the synchronized pin levels (a write there loads the latch), and 3 is unused.

Top module: `gpio_port_ovr`

## Requirements
- R1: Address 0 holds the direction register. A write stores `bus_wdata` and a read returns the stored value. A 1 bit makes the pin an input and a 0 bit makes it an output.
- R2: On a pin that no peripheral claims, direction bit 1 gives `pad_oe`=0. Direction bit 0 gives `pad_oe`=1, with `pad_out` equal to that bit of the latch.
- R3: A read of address 1 returns the latched output value, even when the pin levels differ from it.
- R4: A read of address 2 returns `pad_in`. A change on `pad_in` is not yet visible after one rising clock edge and is visible after the second.
- R5: A write to address 2 loads the latch, exactly as a write to address 1 does. A write to address 3 changes neither register, and a read of address 3 returns 0.
- R6: After reset the direction register reads all ones and the latch reads all zeros. No pin is driven, and with `pu_global`=0 no pull-up is enabled.
- R7: `pad_pu[i]` is 1 exactly when `pu_global` is 1 and pin i is not driven. On an unclaimed pin this equals `pu_global` AND direction bit i.
- R8: When `ser_sel[i]`=1, pin i takes `pad_oe` from `ser_oe[i]` and `pad_out` from `ser_o[i]`. This holds whatever the direction, latch and parallel selects hold.
- R9: For i below `PAR_W` with `par_sel[i]`=1 and `ser_sel[i]`=0, pin i takes `pad_oe` from `par_oe` and `pad_out` from `par_o[i]`. The direction bit has no effect on that pin.
- R10: `par_in` equals the low `PAR_W` bits of the synchronized pin levels, with the same two-edge delay as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pu_global | input | 1 | Shared pull-up enable for all pins |
| ser_sel | input | 8 | Per-pin claim by the serial function |
| ser_oe | input | 8 | Serial output enable per pin |
| ser_o | input | 8 | Serial output data per pin |
| par_sel | input | 3 | Per-pin claim by the parallel path (low pins) |
| par_oe | input | 1 | Parallel path drives its pins when 1 |
| par_o | input | 3 | Parallel output data |
| par_in | output | 3 | Synchronized input data for the parallel path |
| pad_in | input | 8 | Levels seen on the pins |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad weak pull-up enable |

## Verification
All 256 direction values are written with a fixed latch pattern, and each is checked with the shared pull-up bit both off and on. This separates correct direction polarity from inverted polarity and catches pull-ups that ignore the direction mask. The latch is swept while the pins are driven to the complement of each value, which shows whether latch reads come from the pins. Each of the 256 pin values is stepped through the synchronizer and checked after one edge and after two, which detects a missing or extra stage. All serial select masks are crossed with all parallel select masks and both parallel drive settings, so every priority ordering is exercised on every pin.

// File: rtl/gpio_port_pkg.sv
// Package: shared address constants for the I/O port register bus.
// Assumes a two-bit address space with four slots.
package gpio_port_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DIR  = 2'd0;
    localparam logic [ADDR_W-1:0] A_LAT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PIN  = 2'd2;
    localparam logic [ADDR_W-1:0] A_NONE = 2'd3;
endpackage

// File: rtl/gpio_port_regs.sv
// Module: direction and output-latch registers with the read-data mux.
// Assumes single-cycle writes with a combinational read path. Both the
// latch slot and the pin slot load the latch on a write.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      rdata
);

    // Register update: all pins become inputs at reset, latch clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else if (we) begin
            case (addr)
                A_DIR:   dir_q <= wdata;
                A_LAT:   lat_q <= wdata;
                A_PIN:   lat_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux: latch reads and pin reads stay on separate slots
    always_comb begin
        case (addr)
            A_DIR:   rdata = dir_q;
            A_LAT:   rdata = lat_q;
            A_PIN:   rdata = pin_sync;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_sync.sv
// Module: multi-stage synchronizer for asynchronous pin levels.
// Assumes STAGES >= 1. Every stage clears to zero at reset.
module gpio_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Stage chain: each flop takes the previous stage's value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_padmux.sv
// Module: per-pin priority mux that builds the pad controls.
// Priority, highest first: serial claim, parallel claim (low PAR_W pins
// only), then direction and latch. A pull-up is masked on any driven pin.
module gpio_port_padmux #(
    parameter int W     = 8,
    parameter int PAR_W = 3
) (
    input  logic [W-1:0]     dir_q,
    input  logic [W-1:0]     lat_q,
    input  logic             pu_global,
    input  logic [W-1:0]     ser_sel,
    input  logic [W-1:0]     ser_oe,
    input  logic [W-1:0]     ser_o,
    input  logic [PAR_W-1:0] par_sel,
    input  logic             par_oe,
    input  logic [PAR_W-1:0] par_o,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_pu
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i < PAR_W) begin : g_par
            // Pin with a parallel path: three-way priority
            always_comb begin
                if (ser_sel[i]) begin
                    pad_oe[i]  = ser_oe[i];
                    pad_out[i] = ser_o[i];
                end else if (par_sel[i]) begin
                    pad_oe[i]  = par_oe;
                    pad_out[i] = par_o[i];
                end else begin
                    pad_oe[i]  = ~dir_q[i];
                    pad_out[i] = lat_q[i];
                end
            end
        end else begin : g_std
            // Pin without a parallel path: two-way priority
            always_comb begin
                if (ser_sel[i]) begin
                    pad_oe[i]  = ser_oe[i];
                    pad_out[i] = ser_o[i];
                end else begin
                    pad_oe[i]  = ~dir_q[i];
                    pad_out[i] = lat_q[i];
                end
            end
        end
        // Pull-up follows the shared bit, off while the pin is driven
        assign pad_pu[i] = pu_global & ~pad_oe[i];
    end

endmodule

// File: rtl/gpio_port_ovr.sv
// Module: top of the I/O port. Joins the registers, the input
// synchronizer and the pad mux. Assumes pad_in is asynchronous and that
// the peripheral select inputs are synchronous to clk.
module gpio_port_ovr
    import gpio_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int PAR_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              pu_global,
    input  logic [W-1:0]      ser_sel,
    input  logic [W-1:0]      ser_oe,
    input  logic [W-1:0]      ser_o,
    input  logic [PAR_W-1:0]  par_sel,
    input  logic              par_oe,
    input  logic [PAR_W-1:0]  par_o,
    output logic [PAR_W-1:0]  par_in,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu
);

    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] pin_sync;

    gpio_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio_port_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .rdata    (bus_rdata)
    );

    gpio_port_padmux #(.W(W), .PAR_W(PAR_W)) u_mux (
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .pu_global (pu_global),
        .ser_sel   (ser_sel),
        .ser_oe    (ser_oe),
        .ser_o     (ser_o),
        .par_sel   (par_sel),
        .par_oe    (par_oe),
        .par_o     (par_o),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    // Parallel path samples the synchronized low pins
    assign par_in = pin_sync[PAR_W-1:0];

endmodule

// File: rtl/gpio_port_ovr_chk.sv
// Checker: protocol and pad properties of the I/O port, attached to the
// top by bind. Reads the top's internal register nets.
module gpio_port_ovr_chk
    import gpio_port_pkg::*;
#(
    parameter int W     = 8,
    parameter int PAR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      pad_pu,
    input logic [W-1:0]      ser_sel,
    input logic [W-1:0]      ser_oe,
    input logic [PAR_W-1:0]  par_sel,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      lat_q,
    input logic [W-1:0]      pin_sync
);

    logic [1:0]   age;
    logic [W-1:0] par_claim;

    // Cycles since reset, saturating, to guard the two-deep history
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // Parallel claim widened to the port width
    always_comb begin
        par_claim = '0;
        par_claim[PAR_W-1:0] = par_sel;
    end

    a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR) |=> dir_q == $past(bus_wdata));

    a_r5_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_LAT || bus_addr == A_PIN)) |=> lat_q == $past(bus_wdata));

    a_r5_none_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_NONE) |=> ($stable(dir_q) && $stable(lat_q)));

    a_r2_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~ser_sel & ~par_claim & pad_oe) == '0));

    a_r7_pull_off_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    a_r8_serial_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ ser_oe) & ser_sel) == '0));

    a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> pin_sync == $past(pad_in, 2));

endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.W(W), .PAR_W(PAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .ser_sel   (ser_sel),
    .ser_oe    (ser_oe),
    .par_sel   (par_sel),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .pin_sync  (pin_sync)
);

// File: tb/tb_gpio_port_ovr.sv
// Bench: sweeps over direction, latch, pin levels and override masks.
// Expected values are computed from the requirements.
module tb_gpio_port_ovr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pu_global = 1'b0;
    logic [7:0] ser_sel = '0, ser_oe = '0, ser_o = '0;
    logic [2:0] par_sel = '0, par_o = '0;
    logic       par_oe = 1'b0;
    logic [2:0] par_in;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_port_ovr dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pu_global(pu_global),
        .ser_sel(ser_sel), .ser_oe(ser_oe), .ser_o(ser_o), .par_sel(par_sel),
        .par_oe(par_oe), .par_o(par_o), .par_in(par_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r, prev, eoe, eout;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state
        rd(2'd0, r); chk("R6 dir reset", r, 8'hFF);
        rd(2'd1, r); chk("R6 lat reset", r, 8'h00);
        chk("R6 no drive", pad_oe, 8'h00);
        chk("R6 no pull", pad_pu, 8'h00);

        // R1, R2, R7: every direction value with a fixed latch
        wr(2'd1, 8'hA5);
        for (int d = 0; d < 256; d++) begin
            wr(2'd0, 8'(d));
            rd(2'd0, r); chk("R1 dir readback", r, 8'(d));
            chk("R2 oe from dir", pad_oe, ~8'(d));
            chk("R2 out on outputs", pad_out & ~8'(d), 8'hA5 & ~8'(d));
            pu_global = 1'b0; #1 chk("R7 pull off", pad_pu, 8'h00);
            pu_global = 1'b1; #1 chk("R7 pull masked", pad_pu, 8'(d));
            pu_global = 1'b0;
        end

        // R3: latch reads stay on latch while pins show the complement
        wr(2'd0, 8'h00);
        for (int v = 0; v < 256; v++) begin
            pad_in = ~8'(v);
            wr(2'd1, 8'(v));
            @(negedge clk); @(negedge clk);
            rd(2'd1, r); chk("R3 latch not pin", r, 8'(v));
            chk("R2 drives latch", pad_out, 8'(v));
        end

        // R4, R10: two-edge synchronizer on every pin value
        wr(2'd0, 8'hFF);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        prev = 8'h00;
        for (int v = 1; v < 256; v++) begin
            pad_in = 8'(v);
            @(negedge clk);
            rd(2'd2, r); chk("R4 one edge", r, prev);
            chk("R10 one edge", {5'd0, par_in}, {5'd0, prev[2:0]});
            @(negedge clk);
            rd(2'd2, r); chk("R4 two edges", r, 8'(v));
            chk("R10 two edges", {5'd0, par_in}, {5'd0, 3'(v)});
            prev = 8'(v);
        end

        // R5: pin-slot write loads latch; unused slot is inert and reads 0
        wr(2'd0, 8'h5A);
        wr(2'd2, 8'h3C);
        rd(2'd1, r); chk("R5 pin slot write", r, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd1, r); chk("R5 unused slot latch", r, 8'h3C);
        rd(2'd0, r); chk("R5 unused slot dir", r, 8'h5A);
        rd(2'd3, r); chk("R5 unused slot read", r, 8'h00);
        chk("R5 pads unchanged", pad_out & ~8'h5A, 8'h3C & ~8'h5A);

        // R8, R9, R7: every serial mask against every parallel mask
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h55);
        pu_global = 1'b1;
        ser_oe = 8'hC3; ser_o = 8'h96; par_o = 3'b101;
        for (int po = 0; po < 2; po++) begin
            for (int s = 0; s < 256; s++) begin
                for (int p = 0; p < 8; p++) begin
                    ser_sel = 8'(s); par_sel = 3'(p); par_oe = po[0];
                    #1;
                    for (int i = 0; i < 8; i++) begin
                        if (ser_sel[i]) begin
                            eoe[i] = ser_oe[i]; eout[i] = ser_o[i];
                        end else if (i < 3 && par_sel[i]) begin
                            eoe[i] = par_oe; eout[i] = par_o[i];
                        end else begin
                            eoe[i] = ~(8'h0F >> i) & 1'b1; eout[i] = 8'h55 >> i & 1'b1;
                        end
                    end
                    chk("R8 R9 oe priority", pad_oe, eoe);
                    chk("R8 R9 out priority", pad_out & eoe, eout & eoe);
                    chk("R7 pull with overrides", pad_pu, ~eoe);
                end
            end
        end
        finish_run();
    end

endmodule